// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Controller

This block is the bus-facing command controller of a 1K x 8 serial memory that sits on a two-wire I2C bus. It runs on a fast system clock, brings the SCL and SDA lines in through a synchronizer and a majority-vote filter, and finds start and stop conditions and clock edges in the filtered lines. The SDA output is open drain: the block only ever asks for the line to be pulled low. It decodes the address byte and acknowledges the bytes addressed to it. It writes received data bytes into a synchronous byte memory port, and it streams read data back to the master.

Writes cover both single bytes and bursts inside a 16-byte page. At the stop that closes a write, the block raises a one-cycle pulse to start an external write engine. While that engine reports busy, the block leaves its address unacknowledged, so the master can poll for completion. Reads take three forms. A random read sets the address with a write header, followed by a repeated start. A current read continues from the internal pointer. In either form, a low acknowledge from the master keeps the burst going.

Top module: `eeprom_bus_slave`

## Requirements
- R1: While reset is asserted and just after its release, sda_pull, mem_we and wr_commit are all low.
- R2: The address byte is taken MSB first as bits [7:4] = 1010, bit 3 = device select, bits [2:1] = page, bit 0 = direction (1 = read). The block pulls SDA low in the ninth clock only when bits [7:4] are 1010 and bit 3 equals dev_sel. Otherwise it stays off the bus.
- R3: While wr_busy is high, a matching address byte is not acknowledged.
- R4: In a write, the address byte, the word address byte and every data byte are acknowledged. Each data byte is written through the memory port at the 10-bit address {page, word}.
- R5: Within a write burst only the low 4 address bits advance, wrapping from F to 0 while the upper 6 bits stay fixed, so a 17th byte overwrites the location of the first.
- R6: A stop that ends a write with at least one data byte produces a single-cycle wr_commit pulse. A write header followed only by a repeated start, or by a cancelled data byte, produces none.
- R7: A write header plus word address, then a repeated start and a read address byte, returns the byte at {page, word}, MSB first.
- R8: After each read byte a low master acknowledge makes the block send the next address. The address runs through the whole 10-bit space and wraps from 3FF to 000.
- R9: A current read starts at one past the last address read and ignores the page bits of its address byte.
- R10: After a high master acknowledge the block never pulls SDA again until the next start.
- R11: A start at any point aborts the command in progress. A start followed directly by a stop leaves memory untouched, and the next command is decoded normally.
- R12: sda_pull changes only while SCL is low, so the block never creates a start or stop itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 1 | Strap compared with the device-select bit of the address byte |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received |
| sda_pull | output | 1 | High pulls SDA low (open-drain enable) |
| wr_busy | input | 1 | External write engine is busy |
| wr_commit | output | 1 | One-cycle pulse: start the write engine |
| mem_addr | output | 10 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after mem_addr |

## Verification
The patterns cover single-byte writes, a 17-byte page burst that starts two bytes below a page boundary, random reads and current reads, and a sequential read across the top of memory. Together they separate in-page wrap from full-space wrap and a fresh address from a continued pointer. Address bytes with a wrong select bit, a wrong type code and a busy engine show the three reasons for refusing an acknowledge. Aborts made by a start inside the address byte and inside a data byte check that a cancelled command leaves memory and the commit pulse untouched. Extra clocks after a high master acknowledge check that the block stays off the bus.

// File: rtl/eeprom_bus_pkg.sv
package eeprom_bus_pkg;
  localparam int ADDR_W    = 10;
  localparam int BYTE_W    = 8;
  localparam int SEL_W     = ADDR_W - BYTE_W;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WORD, ST_WORD_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_TX, ST_MACK, ST_SKIP
  } slv_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
  } bus_evt_t;
endpackage

// File: rtl/eeprom_line_filter.sv
module eeprom_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  localparam int HALF = FILT_TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   tap_q;
  logic                   vote_d;

  always_comb vote_d = ($countones(tap_q) > HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '1;
      tap_q    <= '1;
      line_out <= 1'b1;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], line_in};
      tap_q    <= {tap_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_out <= vote_d;
    end
  end
endmodule

// File: rtl/eeprom_bus_events.sv
module eeprom_bus_events
  import eeprom_bus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_f,
  input  logic     sda_f,
  output bus_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    evt.start    = scl_q & scl_f & sda_q & ~sda_f;
    evt.stop     = scl_q & scl_f & ~sda_q & sda_f;
    evt.scl_rise = ~scl_q & scl_f;
    evt.scl_fall = scl_q & ~scl_f;
  end
endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
  import eeprom_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3,
  parameter int PAGE_BITS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_sel,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic              wr_busy,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam int HI_W = ADDR_W - PAGE_BITS;

  // line conditioning: index 1 = SCL, index 0 = SDA
  logic [1:0] raw_lines, flt_lines;
  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    eeprom_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_TAPS  (FILT_TAPS)
    ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (raw_lines[g]),
      .line_out(flt_lines[g])
    );
  end

  logic     scl_f, sda_f;
  bus_evt_t evt;
  assign scl_f = flt_lines[1];
  assign sda_f = flt_lines[0];

  eeprom_bus_events u_evt (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_f(scl_f),
    .sda_f(sda_f),
    .evt  (evt)
  );

  slv_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SEL_W-1:0]  page_q, page_d;
  logic              rw_q, rw_d;
  logic              pull_q, pull_d;
  logic              we_q, we_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic              commit_q, commit_d;
  logic              dirty_q, dirty_d;
  logic              ackok_q, ackok_d;
  logic              dev_match;
  logic [PAGE_BITS-1:0] low_next;

  always_comb begin
    dev_match = (sr_q[7:4] == TYPE_CODE) && (sr_q[3] == dev_sel) && !wr_busy;
    low_next  = addr_q[PAGE_BITS-1:0] + PAGE_BITS'(1);
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sr_d     = sr_q;
    addr_d   = addr_q;
    page_d   = page_q;
    rw_d     = rw_q;
    pull_d   = pull_q;
    we_d     = 1'b0;
    wdata_d  = wdata_q;
    commit_d = 1'b0;
    dirty_d  = dirty_q;
    ackok_d  = ackok_q;

    if (evt.start) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      pull_d  = 1'b0;
      dirty_d = 1'b0;
    end else if (evt.stop) begin
      state_d  = ST_IDLE;
      pull_d   = 1'b0;
      commit_d = dirty_q;
      dirty_d  = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (evt.scl_rise && cnt_q != FULL_CNT) begin
            sr_d  = {sr_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (evt.scl_fall && cnt_q == FULL_CNT) begin
            cnt_d = '0;
            if (state_q == ST_DEV) begin
              if (dev_match) begin
                pull_d  = 1'b1;
                page_d  = sr_q[2:1];
                rw_d    = sr_q[0];
                state_d = ST_DEV_ACK;
              end else begin
                state_d = ST_SKIP;
              end
            end else if (state_q == ST_WORD) begin
              pull_d  = 1'b1;
              addr_d  = {page_q, sr_q};
              state_d = ST_WORD_ACK;
            end else begin
              pull_d  = 1'b1;
              we_d    = 1'b1;
              wdata_d = sr_q;
              dirty_d = 1'b1;
              state_d = ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (evt.scl_fall) begin
            if (rw_q) begin
              sr_d    = mem_rdata;
              pull_d  = ~mem_rdata[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_TX;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_WORD;
            end
          end
        end
        ST_WORD_ACK: begin
          if (evt.scl_fall) begin
            pull_d  = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (evt.scl_fall) begin
            pull_d  = 1'b0;
            addr_d  = {addr_q[ADDR_W-1:PAGE_BITS], low_next};
            state_d = ST_WDATA;
          end
        end
        ST_TX: begin
          if (evt.scl_rise) begin
            cnt_d = cnt_q + CNT_W'(1);
          end else if (evt.scl_fall) begin
            if (cnt_q == FULL_CNT) begin
              pull_d  = 1'b0;
              cnt_d   = '0;
              state_d = ST_MACK;
            end else begin
              sr_d   = {sr_q[BYTE_W-2:0], 1'b0};
              pull_d = ~sr_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (evt.scl_rise) begin
            addr_d  = addr_q + ADDR_W'(1);
            ackok_d = ~sda_f;
          end else if (evt.scl_fall) begin
            if (ackok_q) begin
              sr_d    = mem_rdata;
              pull_d  = ~mem_rdata[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_TX;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sr_q     <= '0;
      addr_q   <= '0;
      page_q   <= '0;
      rw_q     <= 1'b0;
      pull_q   <= 1'b0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      commit_q <= 1'b0;
      dirty_q  <= 1'b0;
      ackok_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sr_q     <= sr_d;
      addr_q   <= addr_d;
      page_q   <= page_d;
      rw_q     <= rw_d;
      pull_q   <= pull_d;
      we_q     <= we_d;
      wdata_q  <= wdata_d;
      commit_q <= commit_d;
      dirty_q  <= dirty_d;
      ackok_q  <= ackok_d;
    end
  end

  assign sda_pull  = pull_q;
  assign wr_commit = commit_q;
  assign mem_addr  = addr_q;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/eeprom_bus_slave_chk.sv
module eeprom_bus_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_pull,
  input logic mem_we,
  input logic wr_commit
);
  a_r12_pull_set_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_in);

  a_r12_pull_clr_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_in);

  a_r4_we_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !scl_in);

  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  a_r6_commit_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> scl_in);

  a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
endmodule

bind eeprom_bus_slave eeprom_bus_slave_chk u_chk (.*);

// File: tb/eeprom_bus_slave_test.sv
module eeprom_bus_slave_test;
  localparam int QTR = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dev_sel, wr_busy;
  logic       scl_m, sda_m;
  logic       scl_in, sda_in;
  logic       sda_pull, wr_commit, mem_we;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  assign scl_in = scl_m;
  assign sda_in = sda_m & ~sda_pull;

  eeprom_bus_slave uut (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .scl_in(scl_in), .sda_in(sda_in),
    .sda_pull(sda_pull), .wr_busy(wr_busy), .wr_commit(wr_commit),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  // memory array model, filled during reset
  logic [7:0]  mem_arr [0:1023];
  logic [10:0] init_idx;
  always @(posedge clk) begin
    if (!rst_n) begin
      if (init_idx < 11'd1024) begin
        mem_arr[init_idx[9:0]] <= init_val(int'(init_idx));
        init_idx <= init_idx + 11'd1;
      end
    end else if (mem_we) begin
      mem_arr[mem_addr] <= mem_wdata;
    end
    mem_rdata <= mem_arr[mem_addr];
  end

  int checks = 0, errors = 0, commit_cnt = 0, bad_edge = 0;
  bit done = 0;
  logic prev_pull = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && wr_commit) commit_cnt <= commit_cnt + 1;
    if (rst_n && (sda_pull != prev_pull) && scl_in) bad_edge <= bad_edge + 1;
    prev_pull <= sda_pull;
  end

  // scoreboard
  logic [7:0] exp_mem [0:1023];
  logic [7:0] exp_q [$];
  logic [7:0] rx_byte;
  string      cur_req = "R7";
  logic [9:0] exp_ptr;
  event       rx_evt;
  logic [7:0] wbuf [0:31];

  always @(rx_evt) begin
    automatic logic [7:0] e;
    if (exp_q.size() == 0) chk(1'b0, cur_req, "unexpected byte", int'(rx_byte), 0);
    else begin
      e = exp_q.pop_front();
      chk(rx_byte == e, cur_req, "read byte", int'(rx_byte), int'(e));
    end
  end

  task automatic wq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    wq(); sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_in; wq(); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int j = 7; j >= 0; j--) send_bit(v[j]);
    recv_bit(ack);
  endtask

  task automatic read_bytes(input int n);
    logic b;
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      v = '0;
      for (int j = 0; j < 8; j++) begin recv_bit(b); v = {v[6:0], b}; end
      rx_byte = v;
      -> rx_evt;
      send_bit(k == n - 1);
    end
  endtask

  task automatic write_cmd(input logic [1:0] pg, input logic [7:0] wa, input int n, input string req);
    logic a;
    logic [9:0] ad;
    bus_start();
    send_byte({4'b1010, dev_sel, pg, 1'b0}, a); chk(a == 1'b0, req, "addr ack", a, 0);
    send_byte(wa, a);                            chk(a == 1'b0, req, "word ack", a, 0);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); chk(a == 1'b0, req, "data ack", a, 0);
      ad = {pg, wa[7:4], 4'(int'(wa[3:0]) + k)};
      exp_mem[ad] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic [1:0] pg, input logic [7:0] wa, input int n, input string req);
    logic a;
    bus_start();
    send_byte({4'b1010, dev_sel, pg, 1'b0}, a); chk(a == 1'b0, req, "addr ack", a, 0);
    send_byte(wa, a);                            chk(a == 1'b0, req, "word ack", a, 0);
    bus_start();
    send_byte({4'b1010, dev_sel, pg, 1'b1}, a); chk(a == 1'b0, req, "read addr ack", a, 0);
    for (int k = 0; k < n; k++) exp_q.push_back(exp_mem[10'(int'({pg, wa}) + k)]);
    cur_req = req;
    read_bytes(n);
    bus_stop();
    exp_ptr = 10'(int'({pg, wa}) + n);
  endtask

  task automatic cur_read(input logic [1:0] pg, input int n, input string req);
    logic a;
    bus_start();
    send_byte({4'b1010, dev_sel, pg, 1'b1}, a); chk(a == 1'b0, req, "addr ack", a, 0);
    for (int k = 0; k < n; k++) exp_q.push_back(exp_mem[10'(int'(exp_ptr) + k)]);
    cur_req = req;
    read_bytes(n);
    bus_stop();
    exp_ptr = 10'(int'(exp_ptr) + n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, b;
    int   c0;
    scl_m = 1'b1; sda_m = 1'b1; dev_sel = 1'b1; wr_busy = 1'b0; rst_n = 1'b0; init_idx = '0;
    for (int i = 0; i < 1024; i++) exp_mem[i] = init_val(i);
    repeat (1100) @(negedge clk);
    // R1: outputs idle in reset
    chk(sda_pull == 0 && mem_we == 0 && wr_commit == 0, "R1", "reset outputs",
        {sda_pull, mem_we, wr_commit}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(sda_pull == 0 && mem_we == 0 && wr_commit == 0, "R1", "after reset",
        {sda_pull, mem_we, wr_commit}, 0);

    // R4 / R6: byte write at 0x235, one commit pulse
    wbuf[0] = 8'hA7;
    write_cmd(2'b10, 8'h35, 1, "R4");
    chk(commit_cnt == 1, "R6", "commit after byte write", commit_cnt, 1);

    // R3: busy engine refuses address, then poll succeeds
    wr_busy = 1'b1;
    bus_start();
    send_byte({4'b1010, dev_sel, 2'b10, 1'b0}, a);
    chk(a == 1'b1, "R3", "ack while busy", a, 1);
    bus_stop();
    wr_busy = 1'b0;

    // R7 random read, R6 no commit for read header
    c0 = commit_cnt;
    rand_read(2'b10, 8'h35, 1, "R7");
    chk(commit_cnt == c0, "R6", "no commit after read header", commit_cnt, c0);

    // R9: current read ignores page bits (11), continues at 0x236
    cur_read(2'b11, 2, "R9");

    // R5: page burst of 17 from 0x11E wraps inside 0x110..0x11F
    for (int k = 0; k < 17; k++) wbuf[k] = 8'(8'hC0 + k);
    write_cmd(2'b01, 8'h1E, 17, "R5");
    chk(exp_mem[10'h11E] == 8'hD0, "R5", "model overwrite", exp_mem[10'h11E], 8'hD0);
    rand_read(2'b01, 8'h10, 17, "R5");

    // R8: sequential wrap 3FE..001, then R9 continues at 002
    rand_read(2'b11, 8'hFE, 4, "R8");
    chk(exp_ptr == 10'h002, "R8", "pointer wrap", exp_ptr, 2);
    cur_read(2'b00, 1, "R9");

    // R2: wrong select bit and wrong type code
    bus_start();
    send_byte({4'b1010, ~dev_sel, 2'b00, 1'b1}, a);
    chk(a == 1'b1, "R2", "select mismatch ack", a, 1);
    bus_stop();
    bus_start();
    send_byte({4'b1011, dev_sel, 2'b00, 1'b1}, a);
    chk(a == 1'b1, "R2", "type mismatch ack", a, 1);
    bus_stop();
    dev_sel = 1'b0;
    rand_read(2'b00, 8'h40, 2, "R2");
    dev_sel = 1'b1;

    // R10: after high master ack, no pull on further clocks
    rand_read(2'b00, 8'h80, 1, "R10");
    bus_start();
    send_byte({4'b1010, dev_sel, 2'b00, 1'b1}, a);
    exp_q.push_back(exp_mem[exp_ptr]);
    cur_req = "R10";
    read_bytes(1);
    for (int j = 0; j < 9; j++) begin
      recv_bit(b);
      chk(b == 1'b1, "R10", "bus released", b, 1);
    end
    bus_stop();
    exp_ptr = exp_ptr + 10'd1;

    // R11: cancel inside address byte, then normal command
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    bus_stop();
    chk(sda_pull == 1'b0, "R11", "released after cancel", sda_pull, 0);
    rand_read(2'b00, 8'h50, 1, "R11");

    // R11 / R6: cancel inside a data byte, no write, no commit
    c0 = commit_cnt;
    bus_start();
    send_byte({4'b1010, dev_sel, 2'b00, 1'b0}, a);
    send_byte(8'h50, a);
    for (int j = 0; j < 5; j++) send_bit(1'b0);
    bus_start();
    bus_stop();
    chk(commit_cnt == c0, "R6", "no commit after cancel", commit_cnt, c0);
    rand_read(2'b00, 8'h50, 1, "R11");

    // R12: pull never changed while SCL high
    chk(bad_edge == 0, "R12", "pull edges during SCL high", bad_edge, 0);
    chk(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule